// File: doc/BRIEF.md
# Event Timer with Comparator Channels

The block is a memory-mapped event timer for a system chip. A single 64-bit up-counter advances by one on every clock while the global run bit is set. A parameterized set of comparator channels watches it. A channel fires only in the cycle in which the counter is exactly equal to its comparator. When it fires, it can hold a level interrupt until software clears it, or it can emit a one-cycle pulse. The two low channels can also rearm themselves periodically by adding a stored period to the comparator. Software reaches every register through 32-bit word accesses on a simple request/response port, and read data comes back one cycle after the request is accepted.

A routing bit in the global configuration moves channel 0 onto a fixed tick interrupt line and channel 1 onto a fixed clock-alarm line. This lets the timer replace older fixed-function timers. Periodic rearm uses a one-shot arming flag. While the flag is set, the next comparator write lands on the match value and clears the flag. After that, comparator writes land on the period.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, all comparators and all enables are 0 and every interrupt output is low. The ID word (offset 0x000) reads 0x00008201 for three channels: bits 12:8 hold the channel count minus one, bit 15 flags routing support and bits 7:0 hold revision 0x01. The tick-length word (0x004) reads the femtosecond parameter, 69841279 by default. The global configuration (0x010) reads 0.
- R2: Every request is accepted in its cycle (`req_ready` high). A read gives `rsp_valid` high with its data in the following cycle only, and no response follows a write.
- R3: The counter steps by one per clock while global bit 0 (run) is set and holds while it is clear. It reads as its low word at 0x030 and its high word at 0x034, with the carry between them. A write to either word replaces that word.
- R4: A channel fires only while the counter runs and the compare is exactly equal. A comparator value that the counter has already passed does not fire until the compared width wraps.
- R5: In level mode (channel config bit 0 = 1) an enabled channel sets its status bit (bit i of 0x020) one cycle after the matching cycle. The status bit drives the channel interrupt until a 1 is written to that bit. Writing 0 leaves it set.
- R6: In edge mode (bit 0 = 0) a match gives a single-cycle pulse on the channel interrupt, in the same cycle in which the status bit sets.
- R7: A channel whose enable (config bit 1) is 0 sets no status bit and raises no interrupt on a match.
- R8: For periodic channels (bit 2 periodic, bit 5 arm flag), the first comparator-low write while armed sets the match value and clears bit 5. Later writes set the period. Each match adds the period to the comparator.
- R9: With bit 6 set, a 64-bit-capable channel compares only the low 32 counter bits, wraps its comparator at 32 bits and reads a zero upper word. Otherwise it compares all 64 bits. Channels without 64-bit capability always work in 32-bit form.
- R10: Channels 0 and 1 report bits 3 (periodic capable) and 4 (64-bit capable) as 1. Higher channels report both as 0. On those higher channels bits 2, 5 and 6 read 0 and have no effect, so the channel stays one-shot.
- R11: With global bit 1 (routing) set, channel 0 drives `tick_irq`, channel 1 drives `rtc_irq`, and `irq_out[1:0]` stay low. With it clear, `tick_irq` and `rtc_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| irq_out | output | NUM_CH | Per-channel interrupt lines |
| tick_irq | output | 1 | Routed channel 0 interrupt |
| rtc_irq | output | 1 | Routed channel 1 interrupt |

## Verification
On every cycle the checker enforces the response timing and the counter's step-or-hold rule. It also enforces that status bits stay set until cleared, that a disabled channel or a stopped counter never raises status, and that routing masks the low channel lines. Exact match timing needs directed scenarios, and so do the passed-value and 32-bit wrap cases. The same holds for the armed-write ordering of periodic reload and for the capability limits of the higher channels. Each of those scenarios counts cycles from the accepted run write and samples the interrupt lines at the predicted cycle.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  // global register offsets (low byte, upper address bits zero)
  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_TICK   = 8'h04;
  localparam logic [7:0] OFS_GCFG   = 8'h10;
  localparam logic [7:0] OFS_STS    = 8'h20;
  localparam logic [7:0] OFS_CNT_LO = 8'h30;
  localparam logic [7:0] OFS_CNT_HI = 8'h34;

  // channel window word index
  localparam logic [2:0] CW_CFG = 3'd0;
  localparam logic [2:0] CW_LO  = 3'd2;
  localparam logic [2:0] CW_HI  = 3'd3;

  // global configuration bits
  localparam int GB_RUN = 0;
  localparam int GB_LEG = 1;

  // channel configuration bits
  localparam int CB_LVL  = 0;
  localparam int CB_EN   = 1;
  localparam int CB_PER  = 2;
  localparam int CB_PCAP = 3;
  localparam int CB_WCAP = 4;
  localparam int CB_ARM  = 5;
  localparam int CB_N32  = 6;

  typedef struct packed {
    logic n32;
    logic arm;
    logic per;
    logic en;
    logic lvl;
  } chcfg_t;

  function automatic logic [31:0] id_word(input int nch);
    logic [31:0] w;
    w        = 32'h0000_0001;
    w[12:8]  = 5'(nch - 1);
    w[15]    = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] count
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ld;

  always_comb begin
    cnt_d = cnt_q;
    if (run)   cnt_d = cnt_q + 1'b1;
    if (wr_lo) cnt_d[31:0] = wdata;
    if (wr_hi) cnt_d[CNT_W-1:32] = wdata[HI_W-1:0];
  end

  assign cnt_ld = run | wr_lo | wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter bit PER_CAP  = 1'b1,
  parameter bit WIDE_CAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             run,
  input  logic             cfg_wr,
  input  chcfg_t           cfg_in,
  input  logic             lo_wr,
  input  logic             hi_wr,
  input  logic [31:0]      wdata,
  input  logic             sts_clr,
  output logic [31:0]      cfg_rd,
  output logic [CNT_W-1:0] cmp_rd,
  output logic             sts,
  output logic             irq,
  output logic             en
);
  localparam int HI_W = CNT_W - 32;

  chcfg_t           cfg_q, cfg_d;
  logic [CNT_W-1:0] cmp_q, cmp_d, prd_q, prd_d;
  logic             sts_q, sts_d, pls_q, pls_d;
  logic             narrow, per_eff, hit, fire, cfg_ld, cmp_ld;

  assign per_eff = PER_CAP && cfg_q.per;
  assign narrow  = !WIDE_CAP || cfg_q.n32;
  assign hit     = run && (narrow ? (count[31:0] == cmp_q[31:0]) : (count == cmp_q));
  assign fire    = hit && cfg_q.en;

  // configuration next state
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) begin
      cfg_d.lvl = cfg_in.lvl;
      cfg_d.en  = cfg_in.en;
      cfg_d.per = PER_CAP  & cfg_in.per;
      cfg_d.arm = PER_CAP  & cfg_in.arm;
      cfg_d.n32 = WIDE_CAP & cfg_in.n32;
    end else if (lo_wr && per_eff && cfg_q.arm) begin
      cfg_d.arm = 1'b0;
    end
  end

  // comparator and period next state
  always_comb begin
    cmp_d = cmp_q;
    prd_d = prd_q;
    if (fire && per_eff) begin
      if (narrow) begin
        cmp_d        = '0;
        cmp_d[31:0]  = cmp_q[31:0] + prd_q[31:0];
      end else begin
        cmp_d = cmp_q + prd_q;
      end
    end
    if (lo_wr) begin
      if (per_eff && !cfg_q.arm) prd_d[31:0] = wdata;
      else                       cmp_d[31:0] = wdata;
    end
    if (hi_wr && WIDE_CAP) begin
      if (per_eff && !cfg_q.arm) prd_d[CNT_W-1:32] = wdata[HI_W-1:0];
      else                       cmp_d[CNT_W-1:32] = wdata[HI_W-1:0];
    end
  end

  always_comb begin
    sts_d = (sts_q & ~sts_clr) | fire;
    pls_d = fire & ~cfg_q.lvl;
  end

  assign cfg_ld = cfg_wr | lo_wr;
  assign cmp_ld = (fire & per_eff) | lo_wr | hi_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ld) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      prd_q <= '0;
    end else if (cmp_ld) begin
      cmp_q <= cmp_d;
      prd_q <= prd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      pls_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      pls_q <= pls_d;
    end
  end

  always_comb begin
    cfg_rd          = '0;
    cfg_rd[CB_LVL]  = cfg_q.lvl;
    cfg_rd[CB_EN]   = cfg_q.en;
    cfg_rd[CB_PER]  = cfg_q.per;
    cfg_rd[CB_PCAP] = PER_CAP;
    cfg_rd[CB_WCAP] = WIDE_CAP;
    cfg_rd[CB_ARM]  = cfg_q.arm;
    cfg_rd[CB_N32]  = cfg_q.n32;
    cmp_rd          = cmp_q;
    if (narrow) cmp_rd[CNT_W-1:32] = '0;
  end

  assign sts = sts_q;
  assign irq = cfg_q.lvl ? sts_q : pls_q;
  assign en  = cfg_q.en;
endmodule

// File: rtl/evt_busif.sv
module evt_busif
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter int          ADDR_W  = 12,
  parameter int          CNT_W   = 64,
  parameter logic [31:0] TICK_FS = 32'd69841279
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [1:0]                  gcfg_wd,
  input  logic [CNT_W-1:0]            count,
  input  logic [NUM_CH-1:0]           sts,
  input  logic [NUM_CH-1:0][31:0]     cfg_rd,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_rd,
  output logic                        run,
  output logic                        legacy,
  output logic                        cnt_wr_lo,
  output logic                        cnt_wr_hi,
  output logic                        sts_wr,
  output logic [NUM_CH-1:0]           ch_cfg_wr,
  output logic [NUM_CH-1:0]           ch_lo_wr,
  output logic [NUM_CH-1:0]           ch_hi_wr,
  output logic                        rsp_valid,
  output logic [31:0]                 rsp_data
);
  localparam int HI_W = CNT_W - 32;

  logic        aligned, in_glb, in_ch, wr, rd;
  logic [2:0]  ch_idx, word;
  logic [7:0]  ofs;
  logic        run_q, leg_q, gcfg_wr;
  logic        rv_q;
  logic [31:0] rd_q, rd_d;

  assign aligned = (req_addr[1:0] == 2'b00);
  assign in_glb  = (req_addr[ADDR_W-1:8] == '0);
  assign in_ch   = (req_addr[ADDR_W-1:8] == (ADDR_W-8)'(1));
  assign ofs     = req_addr[7:0];
  assign ch_idx  = req_addr[7:5];
  assign word    = req_addr[4:2];
  assign wr      = req_valid && req_write && aligned;
  assign rd      = req_valid && !req_write;

  assign gcfg_wr   = wr && in_glb && (ofs == OFS_GCFG);
  assign sts_wr    = wr && in_glb && (ofs == OFS_STS);
  assign cnt_wr_lo = wr && in_glb && (ofs == OFS_CNT_LO);
  assign cnt_wr_hi = wr && in_glb && (ofs == OFS_CNT_HI);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic sel;
    assign sel          = wr && in_ch && (ch_idx == 3'(g));
    assign ch_cfg_wr[g] = sel && (word == CW_CFG);
    assign ch_lo_wr[g]  = sel && (word == CW_LO);
    assign ch_hi_wr[g]  = sel && (word == CW_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (gcfg_wr) begin
      run_q <= gcfg_wd[GB_RUN];
      leg_q <= gcfg_wd[GB_LEG];
    end
  end

  always_comb begin
    rd_d = '0;
    if (aligned && in_glb) begin
      case (ofs)
        OFS_ID:     rd_d = id_word(NUM_CH);
        OFS_TICK:   rd_d = TICK_FS;
        OFS_GCFG:   rd_d = {30'd0, leg_q, run_q};
        OFS_STS:    rd_d = 32'(sts);
        OFS_CNT_LO: rd_d = count[31:0];
        OFS_CNT_HI: rd_d = 32'(count[CNT_W-1:32]);
        default:    rd_d = '0;
      endcase
    end else if (aligned && in_ch) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == 3'(i)) begin
          case (word)
            CW_CFG:  rd_d = cfg_rd[i];
            CW_LO:   rd_d = cmp_rd[i][31:0];
            CW_HI:   rd_d = 32'(cmp_rd[i][CNT_W-1:32]);
            default: rd_d = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_q <= '0;
    else if (rd) rd_q <= rd_d;
  end

  assign run       = run_q;
  assign legacy    = leg_q;
  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter int          ADDR_W  = 12,
  parameter int          CNT_W   = 64,
  parameter logic [31:0] TICK_FS = 32'd69841279
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic [NUM_CH-1:0] irq_out,
  output logic              tick_irq,
  output logic              rtc_irq
);
  logic [1:0]                   rst_sync;
  logic                         rst_n;
  logic                         run, legacy;
  logic                         cnt_wr_lo, cnt_wr_hi, cnt_wr_any, sts_wr;
  logic [CNT_W-1:0]             count;
  logic [NUM_CH-1:0]            ch_cfg_wr, ch_lo_wr, ch_hi_wr;
  logic [NUM_CH-1:0]            sts, sts_clr, ch_irq, ch_en;
  logic [NUM_CH-1:0][31:0]      cfg_rd;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_rd;
  chcfg_t                       cfg_in;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  assign req_ready  = 1'b1;
  assign cnt_wr_any = cnt_wr_lo | cnt_wr_hi;

  assign cfg_in.lvl = req_wdata[CB_LVL];
  assign cfg_in.en  = req_wdata[CB_EN];
  assign cfg_in.per = req_wdata[CB_PER];
  assign cfg_in.arm = req_wdata[CB_ARM];
  assign cfg_in.n32 = req_wdata[CB_N32];

  evt_busif #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TICK_FS(TICK_FS)
  ) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .gcfg_wd(req_wdata[1:0]),
    .count(count), .sts(sts), .cfg_rd(cfg_rd), .cmp_rd(cmp_rd),
    .run(run), .legacy(legacy),
    .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi), .sts_wr(sts_wr),
    .ch_cfg_wr(ch_cfg_wr), .ch_lo_wr(ch_lo_wr), .ch_hi_wr(ch_hi_wr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run),
    .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi), .wdata(req_wdata),
    .count(count)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign sts_clr[g] = sts_wr & req_wdata[g];

    evt_channel #(
      .CNT_W(CNT_W), .PER_CAP(g < 2), .WIDE_CAP(g < 2)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .count(count), .run(run),
      .cfg_wr(ch_cfg_wr[g]), .cfg_in(cfg_in),
      .lo_wr(ch_lo_wr[g]), .hi_wr(ch_hi_wr[g]), .wdata(req_wdata),
      .sts_clr(sts_clr[g]),
      .cfg_rd(cfg_rd[g]), .cmp_rd(cmp_rd[g]),
      .sts(sts[g]), .irq(ch_irq[g]), .en(ch_en[g])
    );

    if (g < 2) begin : g_route
      assign irq_out[g] = ch_irq[g] & ~legacy;
    end else begin : g_plain
      assign irq_out[g] = ch_irq[g];
    end
  end

  assign tick_irq = legacy & ch_irq[0];
  assign rtc_irq  = legacy & ch_irq[1];
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              run,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  count,
  input logic [NUM_CH-1:0] sts,
  input logic [NUM_CH-1:0] sts_clr,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_irq,
  input logic              legacy,
  input logic [NUM_CH-1:0] irq_out,
  input logic              tick_irq
);
  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R2
  rsp_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> (count == $past(count) + 1'b1));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));
  // R11
  route_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legacy |-> (!irq_out[0] && !irq_out[1] && (tick_irq == ch_irq[0])));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R5
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[g] && !sts_clr[g]) |=> sts[g]);
    // R7
    sts_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts[g] && !ch_en[g]) |=> !sts[g]);
    // R4
    sts_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts[g] && !run) |=> !sts[g]);
  end
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_write(req_write), .rsp_valid(rsp_valid),
  .run(run), .cnt_wr(cnt_wr_any), .count(count),
  .sts(sts), .sts_clr(sts_clr), .ch_en(ch_en), .ch_irq(ch_irq),
  .legacy(legacy), .irq_out(irq_out), .tick_irq(tick_irq)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
  localparam logic [11:0] A_ID   = 12'h000;
  localparam logic [11:0] A_TICK = 12'h004;
  localparam logic [11:0] A_GCFG = 12'h010;
  localparam logic [11:0] A_STS  = 12'h020;
  localparam logic [11:0] A_CLO  = 12'h030;
  localparam logic [11:0] A_CHI  = 12'h034;

  function automatic logic [11:0] a_cfg(input int c); return 12'h100 + 12'(c * 32); endfunction
  function automatic logic [11:0] a_mlo(input int c); return 12'h108 + 12'(c * 32); endfunction
  function automatic logic [11:0] a_mhi(input int c); return 12'h10C + 12'(c * 32); endfunction

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, tick_irq, rtc_irq;
  logic [31:0] rsp_data;
  logic [2:0]  irq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  evt_timer uut (
    .clk(clk), .arst_n(arst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .irq_out(irq_out), .tick_irq(tick_irq), .rtc_irq(rtc_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst_n = 1'b0;
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R2 no response to write", rsp_valid, 1'b0);
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 read response valid", rsp_valid, 1'b1);
    d = rsp_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 irq lines low", {tick_irq, rtc_irq, irq_out}, 5'b0);
    chk("R2 ready", req_ready, 1'b1);
    bus_rd(A_ID, d);   chk("R1 id word", d, 32'h0000_8201);
    @(negedge clk);
    chk("R2 response one cycle only", rsp_valid, 1'b0);
    bus_rd(A_TICK, d); chk("R1 tick length", d, 32'd69841279);
    bus_rd(A_GCFG, d); chk("R1 global cfg", d, 32'h0);
    bus_rd(A_CLO, d);  chk("R1 counter low", d, 32'h0);
    bus_rd(A_CHI, d);  chk("R1 counter high", d, 32'h0);
    bus_rd(a_cfg(0), d); chk("R10 ch0 caps", d, 32'h18);
    bus_rd(a_cfg(2), d); chk("R10 ch2 caps", d, 32'h0);
    bus_rd(a_mlo(1), d); chk("R1 comparator zero", d, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    do_reset();
    bus_wr(A_GCFG, 32'h1);
    repeat (9) @(negedge clk);
    bus_wr(A_GCFG, 32'h0);
    bus_rd(A_CLO, d); chk("R3 counted steps", d, 32'd10);
    repeat (5) @(negedge clk);
    bus_rd(A_CLO, d); chk("R3 holds when stopped", d, 32'd10);
    bus_wr(A_CHI, 32'd5);
    bus_wr(A_CLO, 32'hFFFF_FFFE);
    bus_wr(A_GCFG, 32'h1);
    @(negedge clk);
    bus_wr(A_GCFG, 32'h0);
    bus_rd(A_CLO, d); chk("R3 low word wraps", d, 32'h0);
    bus_rd(A_CHI, d); chk("R3 carry into high", d, 32'd6);
  endtask

  task automatic t_level();
    logic [31:0] d;
    do_reset();
    bus_wr(a_cfg(0), 32'h43);
    bus_wr(a_mlo(0), 32'd20);
    bus_wr(A_GCFG, 32'h1);
    repeat (20) @(negedge clk);
    chk("R4 no fire before equality", irq_out[0], 1'b0);
    @(negedge clk);
    chk("R5 level raised after match", irq_out[0], 1'b1);
    bus_rd(A_STS, d); chk("R5 status bit", d, 32'h1);
    bus_wr(A_STS, 32'h0);
    chk("R5 write 0 keeps level", irq_out[0], 1'b1);
    bus_wr(A_STS, 32'h1);
    chk("R5 write 1 clears", irq_out[0], 1'b0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    int seen1 = 0;
    do_reset();
    bus_wr(a_cfg(0), 32'h42);
    bus_wr(a_mlo(0), 32'd15);
    bus_wr(a_cfg(1), 32'h41);
    bus_wr(a_mlo(1), 32'd15);
    bus_wr(A_GCFG, 32'h1);
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk);
      if (irq_out[1]) seen1++;
      if (k == 15) chk("R6 low before pulse", irq_out[0], 1'b0);
      if (k == 16) chk("R6 pulse", irq_out[0], 1'b1);
      if (k == 17) chk("R6 pulse one cycle", irq_out[0], 1'b0);
    end
    chk("R7 disabled channel silent", seen1, 0);
    bus_rd(A_STS, d); chk("R7 status only enabled channel", d, 32'h1);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    int pulses = 0;
    do_reset();
    bus_wr(a_cfg(0), 32'h66);
    bus_rd(a_cfg(0), d); chk("R8 armed readback", d, 32'h7E);
    bus_wr(a_mlo(0), 32'd10);
    bus_rd(a_cfg(0), d); chk("R8 arm flag cleared", d, 32'h5E);
    bus_wr(a_mlo(0), 32'd8);
    bus_rd(a_mlo(0), d); chk("R8 second write is period", d, 32'd10);
    bus_wr(A_GCFG, 32'h1);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (irq_out[0]) pulses++;
    end
    bus_wr(A_GCFG, 32'h0);
    chk("R8 periodic pulse count", pulses, 4);
    bus_rd(a_mlo(0), d); chk("R8 comparator advanced", d, 32'd42);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    do_reset();
    bus_wr(A_CLO, 32'hFFFF_FFF0);
    bus_wr(a_cfg(0), 32'h43);
    bus_wr(a_mhi(0), 32'd7);
    bus_wr(a_mlo(0), 32'd4);
    bus_wr(a_cfg(1), 32'h03);
    bus_wr(a_mlo(1), 32'd4);
    bus_wr(a_cfg(2), 32'h03);
    bus_wr(a_mhi(2), 32'd9);
    bus_wr(a_mlo(2), 32'd4);
    bus_wr(A_GCFG, 32'h1);
    repeat (20) @(negedge clk);
    chk("R4 nothing before wrap match", irq_out, 3'b000);
    @(negedge clk);
    chk("R9 32-bit channels fire, 64-bit passed value does not", irq_out, 3'b101);
    bus_rd(a_mhi(0), d); chk("R9 narrow upper reads zero", d, 32'h0);
    bus_rd(a_mhi(2), d); chk("R9 no-wide channel upper zero", d, 32'h0);
  endtask

  task automatic t_noncap();
    logic [31:0] d;
    int pulses = 0;
    do_reset();
    bus_wr(a_cfg(2), 32'h66);
    bus_rd(a_cfg(2), d); chk("R10 periodic/arm/n32 dropped", d, 32'h02);
    bus_wr(a_mlo(2), 32'd6);
    bus_rd(a_mlo(2), d); chk("R10 write goes to comparator", d, 32'd6);
    bus_wr(A_GCFG, 32'h1);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (irq_out[2]) pulses++;
    end
    bus_wr(A_GCFG, 32'h0);
    chk("R10 one-shot single pulse", pulses, 1);
    bus_rd(a_mlo(2), d); chk("R10 comparator not reloaded", d, 32'd6);
    bus_rd(A_STS, d);    chk("R10 status set", d, 32'h4);
  endtask

  task automatic t_route();
    do_reset();
    bus_wr(a_cfg(0), 32'h03);
    bus_wr(a_mlo(0), 32'd5);
    bus_wr(a_cfg(1), 32'h03);
    bus_wr(a_mlo(1), 32'd5);
    bus_wr(A_GCFG, 32'h3);
    repeat (10) @(negedge clk);
    chk("R11 routed lines high", {tick_irq, rtc_irq}, 2'b11);
    chk("R11 channel lines masked", irq_out, 3'b000);
    bus_wr(A_GCFG, 32'h1);
    chk("R11 routed lines low when off", {tick_irq, rtc_irq}, 2'b00);
    chk("R11 channel lines restored", irq_out, 3'b011);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_level();
    t_edge();
    t_periodic();
    t_wrap();
    t_noncap();
    t_route();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule